// File: doc/BRIEF.md
# Inline Memory Write Engine

This block sits behind a command stream that delivers method/value register writes. It keeps a small register array that holds a 64-bit destination base, a geometry block and a control word. Each value written to the data method becomes one 32-bit memory write. Consecutive data words go to consecutive word addresses above the base.

The engine runs as a two-state machine. In `ST_IDLE` no memory request is pending. A data write that is supported takes the **issue** transition to `ST_ISSUE`, which presents the request on the memory port. In `ST_ISSUE` a cycle with `mem_ready` low is a **hold**: the request stays unchanged and the command side is stalled. When `mem_ready` is high, the request retires. If no new supported data write arrives in that cycle, the **retire** transition returns to `ST_IDLE`. If a new supported data write is accepted in the same cycle, the **chain** transition stays in `ST_ISSUE` with the new request.

Writing the control method clears the word offset. The engine supports only linear uploads with a zero x/y/z origin. A data write outside that case raises a one-cycle flag and performs no memory write. A method index beyond the register space is dropped and raises its own flag.

Top module: `inline_upload_engine`

## Requirements
- R1: After reset, `mem_valid`, `err_bad_method` and `err_unsupported` are 0 and `cmd_ready` is 1.
- R2: A memory write targets {reg 0x62, reg 0x63} + 4 × offset. Reg 0x62 supplies address bits 63:32 and reg 0x63 supplies bits 31:0.
- R3: Each accepted write to method 0x6D with supported settings produces exactly one memory write. Its data equals the value written. Its request appears on the cycle after acceptance. The offset then advances by one.
- R4: Any write to method 0x6C (control; bit 0 = linear) clears the offset to zero, whatever value is written.
- R5: A data write is unsupported when control bit 0 is 0, or when any of reg 0x69 (z), reg 0x6A (x) or reg 0x6B (y) is nonzero. An unsupported data write produces no memory write, pulses `err_unsupported` for one cycle on the next cycle, and leaves the offset unchanged.
- R6: A method index of 0x7F or above is ignored. It stores nothing, does not alias onto a lower register, and pulses `err_bad_method` for one cycle on the next cycle.
- R7: While `mem_valid` is 1 and `mem_ready` is 0, `cmd_ready` is 0, and `mem_addr` and `mem_data` hold steady.
- R8: Writes to methods 0x60, 0x61 and 0x64–0x68 (line length, line count, pitch, block shape, width, height, depth) are stored. They have no effect on the addresses or data of memory writes.
- R9: In the cycle where a pending request meets `mem_ready` = 1, `cmd_ready` is 1. A data write accepted in that cycle issues its request on the next cycle without a gap.
- R10: The address sum carries from bit 31 into bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Method write strobe |
| cmd_ready | output | 1 | Engine can accept a method write |
| cmd_method | input | METHOD_W (12) | Method (register) index |
| cmd_value | input | 32 | Method value |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory side accepts the request |
| mem_addr | output | 64 | Byte address of the write |
| mem_data | output | 32 | Word to write |
| err_bad_method | output | 1 | One-cycle pulse: method index out of range |
| err_unsupported | output | 1 | One-cycle pulse: data write in an unsupported mode |

## Verification
The assertions assume that `cmd_method`, `cmd_value` and `cmd_valid` hold still from a rejected offer until the offer is accepted. The bench drives these inputs only at falling edges and samples `cmd_ready` just before the rising edge, so this assumption always holds. The assertions also assume that `mem_ready` changes only between edges, which the bench also respects. The stimulus sweeps several bases, including a carry across bit 32, and burst lengths from one to six. It also covers rejected modes, out-of-range and aliasing method indices, and back-pressured and chained handshakes.

// File: rtl/iue_pkg.sv
package iue_pkg;
    localparam int M_LINE_LEN = 'h60;
    localparam int M_LINE_CNT = 'h61;
    localparam int M_BASE_HI  = 'h62;
    localparam int M_BASE_LO  = 'h63;
    localparam int M_ORG_Z    = 'h69;
    localparam int M_ORG_X    = 'h6A;
    localparam int M_ORG_Y    = 'h6B;
    localparam int M_CTRL     = 'h6C;
    localparam int M_DATA     = 'h6D;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } iue_state_e;
endpackage

// File: rtl/iue_regfile.sv
module iue_regfile
    import iue_pkg::*;
#(
    parameter int NUM_REGS = 127,
    parameter int ADDR_W   = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_value,
    output logic [ADDR_W-1:0] base_addr,
    output logic              linear,
    output logic              origin_zero
);
    logic [31:0] regs [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_value;
        end
    end

    assign base_addr   = ADDR_W'({regs[M_BASE_HI], regs[M_BASE_LO]});
    assign linear      = regs[M_CTRL][0];
    assign origin_zero = (regs[M_ORG_X] == '0) && (regs[M_ORG_Y] == '0)
                         && (regs[M_ORG_Z] == '0);
endmodule

// File: rtl/iue_offset_gen.sv
module iue_offset_gen #(
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 30,
    localparam int PAD_W = ADDR_W - OFS_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] word_addr
);
    logic [OFS_W-1:0] offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       offset <= '0;
        else if (clear)   offset <= '0;
        else if (advance) offset <= offset + 1'b1;
    end

    assign word_addr = base_addr + {{PAD_W{1'b0}}, offset, 2'b00};
endmodule

// File: rtl/inline_upload_engine.sv
module inline_upload_engine
    import iue_pkg::*;
#(
    parameter int METHOD_W = 12,
    parameter int NUM_REGS = 127,
    parameter int OFS_W    = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [METHOD_W-1:0] cmd_method,
    input  logic [31:0]         cmd_value,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [63:0]         mem_addr,
    output logic [31:0]         mem_data,
    output logic                err_bad_method,
    output logic                err_unsupported
);
    localparam int IDX_W = $clog2(NUM_REGS);

    iue_state_e  state, state_nx;
    logic        accept, in_range, is_data, is_ctrl, supported, fire, reject;
    logic [63:0] base_addr, word_addr;
    logic        linear, origin_zero;

    assign accept    = cmd_valid && cmd_ready;
    assign in_range  = cmd_method < METHOD_W'(NUM_REGS);
    assign is_data   = in_range && (cmd_method == METHOD_W'(M_DATA));
    assign is_ctrl   = in_range && (cmd_method == METHOD_W'(M_CTRL));
    assign supported = linear && origin_zero;
    assign fire      = accept && is_data && supported;
    assign reject    = accept && is_data && !supported;

    iue_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(64)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (accept && in_range),
        .wr_idx      (cmd_method[IDX_W-1:0]),
        .wr_value    (cmd_value),
        .base_addr   (base_addr),
        .linear      (linear),
        .origin_zero (origin_zero)
    );

    iue_offset_gen #(.ADDR_W(64), .OFS_W(OFS_W)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept && is_ctrl),
        .advance   (fire),
        .base_addr (base_addr),
        .word_addr (word_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        cmd_ready = 1'b1;
        mem_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fire) state_nx = ST_ISSUE;
            end
            ST_ISSUE: begin
                mem_valid = 1'b1;
                cmd_ready = mem_ready;
                if (mem_ready && !fire) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr        <= '0;
            mem_data        <= '0;
            err_bad_method  <= 1'b0;
            err_unsupported <= 1'b0;
        end else begin
            if (fire) begin
                mem_addr <= word_addr;
                mem_data <= cmd_value;
            end
            err_bad_method  <= accept && !in_range;
            err_unsupported <= reject;
        end
    end
endmodule

// File: rtl/iue_checker.sv
module iue_checker #(
    parameter int METHOD_W = 12,
    parameter int NUM_REGS = 127
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [METHOD_W-1:0] cmd_method,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic [63:0]         mem_addr,
    input logic [31:0]         mem_data,
    input logic                err_bad_method,
    input logic                err_unsupported
);
    AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R7
    AST_STALL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |-> !cmd_ready); // R7
    AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid || mem_ready) |-> cmd_ready); // R9
    AST_BAD_METHOD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_method >= METHOD_W'(NUM_REGS)
        |=> err_bad_method && !mem_valid && !err_unsupported); // R6
    AST_DATA_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_method == METHOD_W'('h6D)
        |=> mem_valid != err_unsupported); // R3
    AST_UNSUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_unsupported |-> !mem_valid && !err_bad_method); // R5
endmodule

bind inline_upload_engine iue_checker #(.METHOD_W(METHOD_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/inline_upload_engine_test.sv
`timescale 1ns/1ps
module inline_upload_engine_test;
    localparam logic [11:0] HI = 12'h062, LO = 12'h063, CTL = 12'h06C, DAT = 12'h06D;
    localparam logic [11:0] OZ = 12'h069, OX = 12'h06A, OY = 12'h06B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, mem_ready = 1'b1;
    logic [11:0] cmd_method = '0;
    logic [31:0] cmd_value = '0;
    logic cmd_ready, mem_valid, err_bad_method, err_unsupported;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;

    int nchk = 0, nfail = 0, got_n = 0, nbad = 0, nuns = 0;
    bit done = 1'b0;
    logic [63:0] got_addr [512];
    logic [31:0] got_data [512];

    always #2.5 clk = ~clk;

    inline_upload_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_method(cmd_method), .cmd_value(cmd_value), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .err_bad_method(err_bad_method), .err_unsupported(err_unsupported)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready && got_n < 512) begin
                got_addr[got_n] = mem_addr;
                got_data[got_n] = mem_data;
                got_n++;
            end
            if (err_bad_method)  nbad++;
            if (err_unsupported) nuns++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [11:0] m, input logic [31:0] v);
        bit taken;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_method = m; cmd_value = v;
        taken = 1'b0;
        while (!taken) begin
            #2;
            taken = cmd_ready;
            @(posedge clk);
            if (!taken) @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_write(input int idx, input logic [63:0] a, input logic [31:0] d,
                                input string req);
        chk(got_addr[idx] == a, req, "address", got_addr[idx], a);
        chk(got_data[idx] == d, "R3", "data", 64'(got_data[idx]), 64'(d));
    endtask

    task automatic run_seq(input logic [63:0] base, input int n, input logic [31:0] seed);
        int start;
        start = got_n;
        cmd(HI, base[63:32]);
        cmd(LO, base[31:0]);
        cmd(CTL, 32'h1);
        for (int i = 0; i < n; i++) cmd(DAT, seed + 32'(i) * 32'h01010101);
        drain();
        chk(got_n - start == n, "R3", "write count", 64'(got_n - start), 64'(n));
        for (int i = 0; i < n; i++)
            expect_write(start + i, base + 64'(4 * i), seed + 32'(i) * 32'h01010101,
                         (base[31:0] > 32'hFFFF_FFF0) ? "R10" : "R2");
    endtask

    initial begin
        logic [63:0] b;
        int s, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(mem_valid == 1'b0, "R1", "mem_valid", 64'(mem_valid), 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", 64'(cmd_ready), 1);
        chk(err_bad_method == 1'b0 && err_unsupported == 1'b0, "R1", "errors",
            64'({err_bad_method, err_unsupported}), 0);

        // R2 R3 R10 sweep of bases and burst lengths
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: b = 64'h0000_0000_0000_0000;
                1: b = 64'h0000_0012_8000_0040;
                2: b = 64'hFFFF_FFFF_0000_1000;
                default: b = 64'h0000_0005_FFFF_FFF8;
            endcase
            for (int n = 1; n <= 6; n++) run_seq(b, n, 32'hA000_0000 + 32'(k * 256 + n));
        end

        // R4 control write clears offset
        b = 64'h0000_0001_0000_0100;
        s = got_n;
        cmd(HI, b[63:32]); cmd(LO, b[31:0]); cmd(CTL, 32'h1);
        for (int i = 0; i < 3; i++) cmd(DAT, 32'h4400 + 32'(i));
        cmd(CTL, 32'hFFFF_FFFF);
        for (int i = 0; i < 2; i++) cmd(DAT, 32'h5500 + 32'(i));
        drain();
        chk(got_n - s == 5, "R4", "count", 64'(got_n - s), 5);
        expect_write(s + 3, b, 32'h5500, "R4");
        expect_write(s + 4, b + 4, 32'h5501, "R4");

        // R5 unsupported modes
        s = got_n; e = nuns;
        cmd(CTL, 32'h1);
        cmd(DAT, 32'h6600);
        cmd(OZ, 32'h1); cmd(DAT, 32'hBAD0); cmd(OZ, 32'h0);
        cmd(OY, 32'h2); cmd(DAT, 32'hBAD1); cmd(OY, 32'h0);
        cmd(OX, 32'h8000_0000); cmd(DAT, 32'hBAD2); cmd(OX, 32'h0);
        drain();
        chk(nuns - e == 3, "R5", "unsupported pulses for z/y/x", 64'(nuns - e), 3);
        chk(got_n - s == 1, "R5", "no write while origin nonzero", 64'(got_n - s), 1);
        cmd(DAT, 32'h6601);
        drain();
        expect_write(s + 1, b + 4, 32'h6601, "R5");
        s = got_n; e = nuns;
        cmd(CTL, 32'h0); cmd(DAT, 32'hBAD3);
        drain();
        chk(nuns - e == 1 && got_n == s, "R5", "non-linear rejected",
            64'(got_n - s), 0);
        cmd(CTL, 32'h3); cmd(DAT, 32'h6602);
        drain();
        expect_write(s, b, 32'h6602, "R5");

        // R6 out-of-range methods, including one aliasing onto 0x62
        s = got_n; e = nbad;
        cmd(12'h07F, 32'h1234);
        cmd(12'h0E2, 32'hDEAD_BEEF);
        cmd(12'h0EC, 32'h0);
        cmd(12'hFFF, 32'h7);
        drain();
        chk(nbad - e == 4, "R6", "bad method pulses", 64'(nbad - e), 4);
        chk(got_n == s, "R6", "no write", 64'(got_n - s), 0);
        cmd(DAT, 32'h7700);
        drain();
        expect_write(s, b + 4, 32'h7700, "R6");

        // R8 geometry registers have no effect
        s = got_n;
        cmd(12'h060, 32'h40); cmd(12'h061, 32'h9);
        for (int m = 'h64; m <= 'h68; m++) cmd(12'(m), 32'hFFFF_0000 + 32'(m));
        cmd(DAT, 32'h8800);
        drain();
        expect_write(s, b + 8, 32'h8800, "R8");

        // R7 R9 back-pressure and chaining
        s = got_n;
        @(negedge clk); mem_ready = 1'b0;
        cmd(DAT, 32'h9900);
        @(negedge clk); #1;
        chk(mem_valid == 1'b1, "R7", "request pending", 64'(mem_valid), 1);
        chk(cmd_ready == 1'b0, "R7", "cmd stalled", 64'(cmd_ready), 0);
        chk(mem_addr == b + 12, "R7", "held address", mem_addr, b + 12);
        fork
            cmd(DAT, 32'h9901);
            begin
                repeat (3) @(negedge clk);
                #1;
                chk(mem_addr == b + 12 && mem_data == 32'h9900, "R7", "still held",
                    mem_addr, b + 12);
                chk(got_n == s, "R7", "nothing retired", 64'(got_n - s), 0);
                @(negedge clk);
                mem_ready = 1'b1;
                #1;
                chk(cmd_ready == 1'b1, "R9", "cmd_ready with mem_ready", 64'(cmd_ready), 1);
            end
        join
        #1;
        chk(mem_valid == 1'b1 && mem_data == 32'h9901, "R9", "chained request",
            64'(mem_data), 64'h9901);
        drain();
        chk(got_n - s == 2, "R9", "two writes", 64'(got_n - s), 2);
        expect_write(s, b + 12, 32'h9900, "R7");
        expect_write(s + 1, b + 16, 32'h9901, "R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule